// File: doc/BRIEF.md
# Dual Synthesizer Host Write Bridge

This block sits between a narrow host write bus and the register ports of two frequency synthesizers that share one reference clock. The host writes a byte together with a select code. The byte lands in one of three holding registers: the data byte, the register address, or a control byte. The data and address bytes drive a bus that both synthesizers share. The control byte chooses which synthesizer sees the host write strobe, drives one reset common to both devices, and requests a register-update event.

The update request is retimed on the falling edge of the reference clock. The single update pulse that reaches both devices therefore rises just after a falling edge and stays clear of the next one, so both synthesizers take new settings on the same cycle. The reference clock is forwarded to both devices on one path. The host write bus has no back-pressure: the bridge accepts every write on the rising edge at which the strobe is high, so no ready signal exists. A write with more than one select line active is refused and recorded in a sticky error flag.

Top module: `dual_synth_bus_bridge`

## Requirements
- R1: While host_wr_i is high on a rising clock edge, host_sel_i = 3'b001 loads host_d_i into the data register, 3'b010 loads the address register, and 3'b100 loads the control register. The data and address registers appear on syn_data_o and syn_addr_o from that edge.
- R2: A write with host_sel_i = 3'b000 loads nothing and leaves sel_err_o unchanged.
- R3: A write with two or more select bits set loads nothing and sets sel_err_o from the next edge. The flag then stays high until reset.
- R4: syn_wr_o[k] equals host_wr_i AND control bit k (k = 0, 1), combinationally. With both bits set, both strobes follow the host strobe.
- R5: syn_rst_o equals control bit 2.
- R6: After control bit 3 goes from 0 to 1, syn_upd_o rises at the next falling clock edge and falls at the falling edge one period later.
- R7: While control bit 3 stays set, no further update pulse appears. Clearing the bit and setting it again gives exactly one new pulse.
- R8: syn_refclk_o follows clk_i.
- R9: While rst_ni is low, all three registers are zero, both write strobes are low, and syn_upd_o and sel_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_d_i | input | 8 | Host write byte |
| host_sel_i | input | 3 | One-hot register select (bit0 data, bit1 address, bit2 control) |
| host_wr_i | input | 1 | Host write strobe |
| syn_data_o | output | 8 | Shared data byte to both synthesizers |
| syn_addr_o | output | 8 | Shared register address to both synthesizers |
| syn_wr_o | output | 2 | Per-synthesizer write strobes |
| syn_rst_o | output | 1 | Shared reset |
| syn_upd_o | output | 1 | Shared retimed update pulse |
| syn_refclk_o | output | 1 | Forwarded reference clock |
| sel_err_o | output | 1 | Sticky multiple-select error |

## Verification
A corrupted holding register shows at the ports within one cycle: the data and address bytes are outputs, and a wrong control byte appears at once in the gated strobes or the shared reset. An edge detector in the retimer that is stuck or misaligned either drops the update pulse, lengthens it past one period, or repeats it while the request is held. This is visible half a cycle after the request is loaded. A lost error flag shows on the cycle after the offending write.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int HOST_W   = 8;
  localparam int NUM_DEV  = 2;
  localparam int NUM_REG  = 3;
  typedef enum int {REG_DATA = 0, REG_ADDR = 1, REG_CTRL = 2} reg_idx_e;
  localparam int CB_RESET = NUM_DEV;
  localparam int CB_UPDATE = NUM_DEV + 1;
endpackage

// File: rtl/dsb_host_regs.sv
module dsb_host_regs #(
  parameter int W = 8,
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wdata_i,
  input  logic [N-1:0] sel_i,
  input  logic         wr_i,
  output logic [W-1:0] reg_q [N],
  output logic         err_q
);
  logic multi_sel;
  always_comb multi_sel = ($countones(sel_i) > 1);

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        reg_q[i] <= '0;
      else if (wr_i && (sel_i == N'(1 << i)))
        reg_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      err_q <= 1'b0;
    else if (wr_i && multi_sel)
      err_q <= 1'b1;
  end
endmodule

// File: rtl/dsb_strobe_gate.sv
module dsb_strobe_gate #(
  parameter int N = 2
) (
  input  logic         wr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] wr_o
);
  for (genvar k = 0; k < N; k++) begin : g_dev
    assign wr_o[k] = wr_i & en_i[k];
  end
endmodule

// File: rtl/dsb_update_retimer.sv
module dsb_update_retimer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pulse_o
);
  logic req_seen;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_seen <= 1'b0;
      pulse_o  <= 1'b0;
    end else begin
      req_seen <= req_i;
      pulse_o  <= req_i & ~req_seen;
    end
  end
endmodule

// File: rtl/dual_synth_bus_bridge.sv
module dual_synth_bus_bridge
  import dsb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HOST_W-1:0] host_d_i,
  input  logic [NUM_REG-1:0] host_sel_i,
  input  logic              host_wr_i,
  output logic [HOST_W-1:0] syn_data_o,
  output logic [HOST_W-1:0] syn_addr_o,
  output logic [NUM_DEV-1:0] syn_wr_o,
  output logic              syn_rst_o,
  output logic              syn_upd_o,
  output logic              syn_refclk_o,
  output logic              sel_err_o
);
  logic [HOST_W-1:0] regs [NUM_REG];
  logic [HOST_W-1:0] ctrl;

  dsb_host_regs #(.W(HOST_W), .N(NUM_REG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wdata_i (host_d_i),
    .sel_i   (host_sel_i),
    .wr_i    (host_wr_i),
    .reg_q   (regs),
    .err_q   (sel_err_o)
  );

  assign syn_data_o = regs[REG_DATA];
  assign syn_addr_o = regs[REG_ADDR];
  assign ctrl       = regs[REG_CTRL];
  assign syn_rst_o  = ctrl[CB_RESET];

  dsb_strobe_gate #(.N(NUM_DEV)) u_gate (
    .wr_i (host_wr_i),
    .en_i (ctrl[NUM_DEV-1:0]),
    .wr_o (syn_wr_o)
  );

  dsb_update_retimer u_upd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (ctrl[CB_UPDATE]),
    .pulse_o (syn_upd_o)
  );

  assign syn_refclk_o = clk_i;
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] host_d_i,
  input logic [2:0] host_sel_i,
  input logic       host_wr_i,
  input logic [7:0] syn_data_o,
  input logic [7:0] syn_addr_o,
  input logic [1:0] syn_wr_o,
  input logic       syn_upd_o,
  input logic       sel_err_o
);
  p_load_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_sel_i == 3'b001) |=> (syn_data_o == $past(host_d_i)));

  p_load_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_sel_i == 3'b010) |=> (syn_addr_o == $past(host_d_i)));

  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_err_o |=> sel_err_o);

  p_err_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && $countones(host_sel_i) > 1) |=> sel_err_o);

  p_multi_noload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && $countones(host_sel_i) > 1) |=> ($stable(syn_data_o) && $stable(syn_addr_o)));

  p_strobe_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_wr_o != 2'b00) |-> host_wr_i);

  p_upd_width_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(syn_upd_o) |=> !syn_upd_o);
endmodule

bind dual_synth_bus_bridge dsb_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_d_i   (host_d_i),
  .host_sel_i (host_sel_i),
  .host_wr_i  (host_wr_i),
  .syn_data_o (syn_data_o),
  .syn_addr_o (syn_addr_o),
  .syn_wr_o   (syn_wr_o),
  .syn_upd_o  (syn_upd_o),
  .sel_err_o  (sel_err_o)
);

// File: tb/sim_dual_synth_bus_bridge.sv
`timescale 1ns/1ps
module sim_dual_synth_bus_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] d = '0;
  logic [2:0] sel = '0;
  logic       wr = 1'b0;
  logic [7:0] data_o, addr_o;
  logic [1:0] wr_o;
  logic       rst_o, upd_o, refclk_o, err_o;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_data = '0, m_addr = '0, m_ctrl = '0;
  logic       m_err = 1'b0;

  always #2 clk = ~clk;

  dual_synth_bus_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_d_i(d), .host_sel_i(sel), .host_wr_i(wr),
    .syn_data_o(data_o), .syn_addr_o(addr_o), .syn_wr_o(wr_o), .syn_rst_o(rst_o),
    .syn_upd_o(upd_o), .syn_refclk_o(refclk_o), .sel_err_o(err_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ones3(input logic [2:0] s);
    return int'(s[0]) + int'(s[1]) + int'(s[2]);
  endfunction

  // apply a write in the current cycle and advance the model at the next edge
  task automatic hwrite(input logic [2:0] s, input logic [7:0] v, input logic w);
    @(posedge clk); #1;
    d = v; sel = s; wr = w;
    #1;
    chk("R4 strobes", {6'b0, wr_o}, {6'b0, w & m_ctrl[1], w & m_ctrl[0]});
    if (w) begin
      if (ones3(s) > 1) m_err = 1'b1;
      else if (s == 3'b001) m_data = v;
      else if (s == 3'b010) m_addr = v;
      else if (s == 3'b100) m_ctrl = v;
    end
    @(posedge clk); #1;
    wr = 1'b0; sel = '0;
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R1 data"}, data_o, m_data);
    chk({tag, " R1 addr"}, addr_o, m_addr);
    chk({tag, " R3 err"}, {7'b0, err_o}, {7'b0, m_err});
    chk({tag, " R5 reset out"}, {7'b0, rst_o}, {7'b0, m_ctrl[2]});
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    #9;
    // R9 reset state
    chk("R9 data", data_o, 8'h00);
    chk("R9 addr", addr_o, 8'h00);
    chk("R9 strobes", {6'b0, wr_o}, 8'h00);
    chk("R9 upd", {7'b0, upd_o}, 8'h00);
    chk("R9 err", {7'b0, err_o}, 8'h00);
    chk("R9 rst", {7'b0, rst_o}, 8'h00);
    rst_n = 1'b1;

    // R8 clock passthrough, sampled at both levels
    @(posedge clk); #1; chk("R8 high", {7'b0, refclk_o}, 8'h01);
    @(negedge clk); #1; chk("R8 low", {7'b0, refclk_o}, 8'h00);

    // R1 directed loads
    hwrite(3'b001, 8'hA5, 1'b1); check_state("dir");
    hwrite(3'b010, 8'h3C, 1'b1); check_state("dir");
    // R2 no select: nothing loads, no error
    hwrite(3'b000, 8'hFF, 1'b1); check_state("R2");
    // R4 both enables, then single
    hwrite(3'b100, 8'h03, 1'b1); check_state("R4");
    hwrite(3'b001, 8'h11, 1'b1); check_state("R4");
    hwrite(3'b100, 8'h02, 1'b1);
    hwrite(3'b010, 8'h22, 1'b1); check_state("R4");
    // R5 shared reset
    hwrite(3'b100, 8'h04, 1'b1); check_state("R5");
    hwrite(3'b100, 8'h00, 1'b1); check_state("R5");

    // R6 update pulse timing
    @(posedge clk); #1; d = 8'h08; sel = 3'b100; wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0; sel = '0; m_ctrl = 8'h08;
    chk("R6 before falling edge", {7'b0, upd_o}, 8'h00);
    #2; chk("R6 after falling edge", {7'b0, upd_o}, 8'h01);
    #2; chk("R6 still high at rising edge", {7'b0, upd_o}, 8'h01);
    #2; chk("R6 ends after one period", {7'b0, upd_o}, 8'h00);
    // R7 held request gives no repeat
    for (int i = 0; i < 6; i++) begin
      #4; chk("R7 no repeat", {7'b0, upd_o}, 8'h00);
    end
    hwrite(3'b100, 8'h00, 1'b1);
    @(posedge clk); #1; d = 8'h08; sel = 3'b100; wr = 1'b1;
    @(posedge clk); #1; wr = 1'b0; sel = '0; m_ctrl = 8'h08;
    #2; chk("R7 rearmed pulse", {7'b0, upd_o}, 8'h01);
    #4; chk("R7 rearmed pulse ends", {7'b0, upd_o}, 8'h00);
    hwrite(3'b100, 8'h00, 1'b1);

    // R3 multiple select: no load, sticky error
    hwrite(3'b011, 8'h77, 1'b1); check_state("R3");
    hwrite(3'b001, 8'h55, 1'b1); check_state("R3 sticky");

    // random mix; update bit kept clear so syn_upd_o must stay low
    for (int i = 0; i < 300; i++) begin
      logic [2:0] rs;
      logic [7:0] rv;
      rs = 3'($urandom);
      rv = 8'($urandom);
      if (rs == 3'b100) rv = rv & 8'hF7;
      hwrite(rs, rv, 1'($urandom));
      check_state("rand");
      chk("R6 idle", {7'b0, upd_o}, 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule